// File: doc/BRIEF.md
# Dual-Request Edge/Level Interrupt Controller

This block collects up to 32 interrupt sources and presents them on two request lines and one wake line. A three-bit trigger code per source chooses one of five detection kinds: rising edge, falling edge, both edges, active-high level or active-low level. Edge events are caught in two separate latches, one per direction. Level sources follow their input directly. Software acknowledges an edge by writing a one to the rising or falling acknowledge address. That write clears the latch bit and also clears the source's enable bit, so the handler must re-enable the source when it is done.

All control state is held in seven per-source words: three trigger-code planes, an input-select word, a steering word, a wake word and an enable word. Each word has its own read, set and clear addresses on a small single-cycle bus. Writes take effect at the clock edge. Reads are combinational. Two status words show the enabled pending sources steered to each request line. A test word can stand in for the external pin of any source whose input-select bit is cleared.

Top module: `dual_req_irq_ctrl`

## Requirements
- R1: The trigger code of source i is {plane2[i],plane1[i],plane0[i]}. The codes are 001 rising edge, 010 falling edge, 011 both edges, 101 high level and 110 low level. Code 000 disables the source. A rising-only source never records a falling edge, and a falling-only source never becomes pending on a rise.
- R2: Control word k (plane0=0, plane1=1, plane2=2, input-select=3, steering=4, wake=5, enable=6) is read at address 4k and set at 4k+1. It is cleared at 4k+2. On a set or clear write, each 1 bit in the data changes only that bit, and each 0 bit leaves its bit unchanged.
- R3: A pending, enabled source whose steering bit is 1 drives req0_o. One whose steering bit is 0 drives req1_o. Each request output is the OR of its routed sources.
- R4: Rising and falling detections are held in separate latches, read at 0x1C and 0x1D. Writing ones to 0x1C clears the chosen rising latch bits, and writing ones to 0x1D clears the chosen falling latch bits.
- R5: A cleared enable bit blocks the source from the status words and the request outputs. Acknowledging through 0x1C or 0x1D also clears the enable bit of each acknowledged source.
- R6: wake_o is the OR of pending sources whose wake bit is set, whatever their enable bit. The wake bit is set and cleared apart from the enable bit.
- R7: Address 0x1E reads the enabled pending sources steered to req0_o, and 0x1F reads those steered to req1_o.
- R8: Reset leaves all trigger planes, the enable word and the wake word at zero. The steering and input-select words reset to all ones. The latches and the test word (0x20) reset to zero.
- R9: Each of the seven control words reads back its current value at its read address.
- R10: An edge-pending bit stays set after its input returns, until it is acknowledged. A level source stops being pending as soon as its input leaves the active polarity.
- R11: Codes 100 and 111 act as disabled. Such a source never becomes pending, never sets a latch and never drives a request output.
- R12: When a source's input-select bit is 0, its external pin is ignored and bit i of the test word (written and read at 0x20) is used as its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Asynchronous source pins |
| bus_wr_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | NUM_SRC | Write data |
| bus_rdata_o | output | NUM_SRC | Combinational read data |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wake request |

## Verification
Any fault in a latch, an enable bit or a steering bit shows at the ports within a few cycles. An edge on a pin reaches its latch and the status words three clocks after the pin changes. A write to a control word shows on readback, status and requests in the next cycle. So a dropped acknowledge, a missing enable clear or a request on the wrong line appears on the very next read of the latch, enable or status address, or on the request pins themselves. The stimulus runs every trigger code, including the two invalid ones, and both steering directions. It then checks that edge bits hold after the pin reverts while level bits follow the pin.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [2:0] {
        MODE_OFF  = 3'b000,
        MODE_RISE = 3'b001,
        MODE_FALL = 3'b010,
        MODE_BOTH = 3'b011,
        MODE_BAD4 = 3'b100,
        MODE_HIGH = 3'b101,
        MODE_LOW  = 3'b110,
        MODE_BAD7 = 3'b111
    } trig_mode_e;

    typedef struct packed {
        logic on_rise;
        logic on_fall;
        logic lvl_high;
        logic lvl_low;
    } trig_sel_t;

    typedef enum logic [2:0] {
        CTL_PLANE0 = 3'd0,
        CTL_PLANE1 = 3'd1,
        CTL_PLANE2 = 3'd2,
        CTL_INSEL  = 3'd3,
        CTL_STEER  = 3'd4,
        CTL_WAKE   = 3'd5,
        CTL_ENABLE = 3'd6,
        CTL_MISC   = 3'd7
    } ctl_id_e;

    localparam int NUM_CTL = 7;

    localparam logic [1:0] OP_READ = 2'd0;
    localparam logic [1:0] OP_SET  = 2'd1;
    localparam logic [1:0] OP_CLR  = 2'd2;

    localparam logic [5:0] ADDR_RISE  = 6'h1C;
    localparam logic [5:0] ADDR_FALL  = 6'h1D;
    localparam logic [5:0] ADDR_STAT0 = 6'h1E;
    localparam logic [5:0] ADDR_STAT1 = 6'h1F;
    localparam logic [5:0] ADDR_TEST  = 6'h20;

    function automatic trig_sel_t decode_mode(logic [2:0] code);
        trig_sel_t t;
        t = '0;
        case (trig_mode_e'(code))
            MODE_RISE: t.on_rise  = 1'b1;
            MODE_FALL: t.on_fall  = 1'b1;
            MODE_BOTH: begin t.on_rise = 1'b1; t.on_fall = 1'b1; end
            MODE_HIGH: t.lvl_high = 1'b1;
            MODE_LOW:  t.lvl_low  = 1'b1;
            default:   t = '0;
        endcase
        return t;
    endfunction

    function automatic logic ctl_resets_high(int id);
        return (id == int'(CTL_INSEL)) || (id == int'(CTL_STEER));
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
    import irqc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig,
    input  logic [N-1:0] plane0,
    input  logic [N-1:0] plane1,
    input  logic [N-1:0] plane2,
    input  logic [N-1:0] rise_ack,
    input  logic [N-1:0] fall_ack,
    output logic [N-1:0] pending,
    output logic [N-1:0] rise_lat,
    output logic [N-1:0] fall_lat
);
    logic [N-1:0] prev_q;
    logic [N-1:0] rise_nxt, fall_nxt, level_hit;

    for (genvar i = 0; i < N; i++) begin : g_src
        trig_sel_t ts;
        assign ts = decode_mode({plane2[i], plane1[i], plane0[i]});
        // a fresh edge wins over an acknowledge in the same cycle
        assign rise_nxt[i]  = (ts.on_rise & sig[i] & ~prev_q[i])
                            | (rise_lat[i] & ~rise_ack[i]);
        assign fall_nxt[i]  = (ts.on_fall & ~sig[i] & prev_q[i])
                            | (fall_lat[i] & ~fall_ack[i]);
        assign level_hit[i] = (ts.lvl_high & sig[i]) | (ts.lvl_low & ~sig[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            rise_lat <= '0;
            fall_lat <= '0;
        end else begin
            prev_q   <= sig;
            rise_lat <= rise_nxt;
            fall_lat <= fall_nxt;
        end
    end

    assign pending = rise_lat | fall_lat | level_hit;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N  = 32,
    parameter int AW = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr,
    input  logic [AW-1:0]                 addr,
    input  logic [N-1:0]                  wdata,
    input  logic [N-1:0]                  rise_lat,
    input  logic [N-1:0]                  fall_lat,
    input  logic [N-1:0]                  stat0,
    input  logic [N-1:0]                  stat1,
    output logic [NUM_CTL-1:0][N-1:0]     ctl_q,
    output logic [N-1:0]                  test_q,
    output logic [N-1:0]                  rise_ack,
    output logic [N-1:0]                  fall_ack,
    output logic [N-1:0]                  rdata
);
    logic [2:0] id;
    logic [1:0] op;
    logic       ctl_space;

    assign id        = addr[4:2];
    assign op        = addr[1:0];
    assign ctl_space = (addr[AW-1:5] == '0) && (id != CTL_MISC);
    assign rise_ack  = (wr && addr == AW'(ADDR_RISE)) ? wdata : '0;
    assign fall_ack  = (wr && addr == AW'(ADDR_FALL)) ? wdata : '0;

    for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
        logic [N-1:0] set_v, clr_v;
        always_comb begin
            set_v = (wr && ctl_space && id == 3'(g) && op == OP_SET) ? wdata : '0;
            clr_v = (wr && ctl_space && id == 3'(g) && op == OP_CLR) ? wdata : '0;
            if (g == int'(CTL_ENABLE)) begin
                clr_v = clr_v | rise_ack | fall_ack;
            end
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_q[g] <= ctl_resets_high(g) ? '1 : '0;
            end else begin
                ctl_q[g] <= (ctl_q[g] | set_v) & ~clr_v;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            test_q <= '0;
        end else if (wr && addr == AW'(ADDR_TEST)) begin
            test_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (ctl_space) begin
            if (op == OP_READ) begin
                rdata = ctl_q[id];
            end
        end else begin
            case (addr)
                AW'(ADDR_RISE):  rdata = rise_lat;
                AW'(ADDR_FALL):  rdata = fall_lat;
                AW'(ADDR_STAT0): rdata = stat0;
                AW'(ADDR_STAT1): rdata = stat1;
                AW'(ADDR_TEST):  rdata = test_q;
                default:         rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dual_req_irq_ctrl.sv
module dual_req_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [NUM_SRC-1:0] bus_wdata_i,
    output logic [NUM_SRC-1:0] bus_rdata_o,
    output logic               req0_o,
    output logic               req1_o,
    output logic               wake_o
);
    logic [NUM_CTL-1:0][NUM_SRC-1:0] ctl_q;
    logic [NUM_SRC-1:0] test_q, rise_ack, fall_ack, rise_lat, fall_lat;
    logic [NUM_SRC-1:0] synced, chosen, pending, stat0, stat1;
    logic [NUM_SRC-1:0] mask_q, assign_q, wake_q, insel_q;

    assign mask_q   = ctl_q[CTL_ENABLE];
    assign assign_q = ctl_q[CTL_STEER];
    assign wake_q   = ctl_q[CTL_WAKE];
    assign insel_q  = ctl_q[CTL_INSEL];

    irqc_sync #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .d(src_i), .q(synced)
    );

    // test word replaces the pin after the synchronizer
    assign chosen = (insel_q & synced) | (~insel_q & test_q);

    irqc_detect #(.N(NUM_SRC)) det_i (
        .clk(clk), .rst(rst), .sig(chosen),
        .plane0(ctl_q[CTL_PLANE0]), .plane1(ctl_q[CTL_PLANE1]),
        .plane2(ctl_q[CTL_PLANE2]),
        .rise_ack(rise_ack), .fall_ack(fall_ack),
        .pending(pending), .rise_lat(rise_lat), .fall_lat(fall_lat)
    );

    assign stat0 = pending & mask_q & assign_q;
    assign stat1 = pending & mask_q & ~assign_q;

    irqc_regs #(.N(NUM_SRC), .AW(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .wr(bus_wr_i), .addr(bus_addr_i),
        .wdata(bus_wdata_i), .rise_lat(rise_lat), .fall_lat(fall_lat),
        .stat0(stat0), .stat1(stat1), .ctl_q(ctl_q), .test_q(test_q),
        .rise_ack(rise_ack), .fall_ack(fall_ack), .rdata(bus_rdata_o)
    );

    assign req0_o = |stat0;
    assign req1_o = |stat1;
    assign wake_o = |(pending & wake_q);
endmodule

// File: rtl/dual_req_irq_ctrl_chk.sv
module dual_req_irq_ctrl_chk
    import irqc_pkg::*;
#(
    parameter int N  = 32,
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_wr_i,
    input logic [AW-1:0] bus_addr_i,
    input logic [N-1:0]  bus_wdata_i,
    input logic          req0_o,
    input logic          req1_o,
    input logic          wake_o,
    input logic [N-1:0]  mask_q,
    input logic [N-1:0]  assign_q,
    input logic [N-1:0]  wake_q
);
    assert_req0_routed_R3: assert property (@(posedge clk) disable iff (rst)
        req0_o |-> ((mask_q & assign_q) != '0));

    assert_req1_routed_R3: assert property (@(posedge clk) disable iff (rst)
        req1_o |-> ((mask_q & ~assign_q) != '0));

    assert_ack_clears_enable_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && (bus_addr_i == AW'(ADDR_RISE) || bus_addr_i == AW'(ADDR_FALL)))
        |=> ((mask_q & $past(bus_wdata_i)) == '0));

    assert_enable_set_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_i && bus_addr_i == AW'({CTL_ENABLE, OP_SET}))
        |=> ((mask_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    assert_wake_needs_bit_R6: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (wake_q != '0));
endmodule

bind dual_req_irq_ctrl dual_req_irq_ctrl_chk #(.N(NUM_SRC), .AW(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .req0_o(req0_o), .req1_o(req1_o),
    .wake_o(wake_o), .mask_q(mask_q), .assign_q(assign_q), .wake_q(wake_q)
);

// File: tb/dual_req_irq_ctrl_tb_top.sv
module dual_req_irq_ctrl_tb_top;
    localparam int N  = 32;
    localparam int AW = 6;

    localparam logic [AW-1:0] P0_RD = 6'h00, P0_SET = 6'h01, P0_CLR = 6'h02;
    localparam logic [AW-1:0] P1_RD = 6'h04, P1_SET = 6'h05, P1_CLR = 6'h06;
    localparam logic [AW-1:0] P2_RD = 6'h08, P2_SET = 6'h09, P2_CLR = 6'h0A;
    localparam logic [AW-1:0] IS_RD = 6'h0C, IS_CLR = 6'h0E;
    localparam logic [AW-1:0] ST_RD = 6'h10, ST_CLR = 6'h12;
    localparam logic [AW-1:0] WK_RD = 6'h14, WK_SET = 6'h15, WK_CLR = 6'h16;
    localparam logic [AW-1:0] EN_RD = 6'h18, EN_SET = 6'h19, EN_CLR = 6'h1A;
    localparam logic [AW-1:0] A_RISE = 6'h1C, A_FALL = 6'h1D;
    localparam logic [AW-1:0] A_S0 = 6'h1E, A_S1 = 6'h1F, A_TEST = 6'h20;

    localparam int K_RD = 0, K_REQ0 = 1, K_REQ1 = 2, K_WAKE = 3;

    logic clk = 1'b0;
    logic rst;
    logic [N-1:0]  src_i;
    logic          bus_wr_i;
    logic [AW-1:0] bus_addr_i;
    logic [N-1:0]  bus_wdata_i;
    logic [N-1:0]  bus_rdata_o;
    logic          req0_o, req1_o, wake_o;

    always #10 clk = ~clk;

    dual_req_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .src_i(src_i), .bus_wr_i(bus_wr_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .req0_o(req0_o), .req1_o(req1_o),
        .wake_o(wake_o)
    );

    typedef struct {
        int            kind;
        logic [AW-1:0] addr;
        logic [N-1:0]  exp;
        string         tag;
    } item_t;

    item_t sb_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    item_t it;
    logic [N-1:0] got;

    // monitor: compares queued expectations away from the clock edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            case (it.kind)
                K_REQ0:  got = {{(N-1){1'b0}}, req0_o};
                K_REQ1:  got = {{(N-1){1'b0}}, req1_o};
                K_WAKE:  got = {{(N-1){1'b0}}, wake_o};
                default: got = bus_rdata_o;
            endcase
            checks++;
            if (got !== it.exp) begin
                fails++;
                $display("FAIL %s: kind %0d addr 0x%0h got 0x%08h expected 0x%08h",
                         it.tag, it.kind, it.addr, got, it.exp);
            end
        end
    end

    task automatic expect_v(input int kind, input logic [AW-1:0] a,
                            input logic [N-1:0] e, input string tag);
        item_t x;
        @(posedge clk);
        #2;
        bus_addr_i = a;
        x.kind = kind; x.addr = a; x.exp = e; x.tag = tag;
        sb_q.push_back(x);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
        @(posedge clk);
        #2;
        bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(posedge clk);
        #2;
        bus_wr_i = 1'b0; bus_wdata_i = '0;
    endtask

    task automatic pin(input int idx, input logic v);
        @(posedge clk);
        #2;
        src_i[idx] = v;
        repeat (3) @(posedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run hung, got no end expected end");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; src_i = '0; bus_wr_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R8 / R9 reset values through readback
        expect_v(K_RD, P0_RD, 32'h0, "R8 plane0");
        expect_v(K_RD, P2_RD, 32'h0, "R8 plane2");
        expect_v(K_RD, IS_RD, 32'hFFFF_FFFF, "R8 insel");
        expect_v(K_RD, ST_RD, 32'hFFFF_FFFF, "R8 steer");
        expect_v(K_RD, WK_RD, 32'h0, "R8 wake");
        expect_v(K_RD, EN_RD, 32'h0, "R8 enable");
        expect_v(K_RD, A_TEST, 32'h0, "R8 test");
        expect_v(K_REQ0, '0, 32'h0, "R8 req0");
        expect_v(K_REQ1, '0, 32'h0, "R8 req1");

        // R2 set and clear only touch the one bits
        wr(P0_SET, 32'hF000_000F);
        wr(P0_CLR, 32'h5000_0005);
        expect_v(K_RD, P0_RD, 32'hA000_000A, "R2 set/clear");
        wr(P0_CLR, 32'hFFFF_FFFF);
        expect_v(K_RD, P0_RD, 32'h0, "R2 clear all");

        // source 0 rising, steered to req0
        wr(P0_SET, 32'h1);
        wr(EN_SET, 32'h1);
        pin(0, 1'b1);
        expect_v(K_RD, A_RISE, 32'h1, "R4 rise latch");
        expect_v(K_RD, A_S0, 32'h1, "R7 status0");
        expect_v(K_REQ0, '0, 32'h1, "R3 req0 high");
        expect_v(K_REQ1, '0, 32'h0, "R3 req1 low");
        pin(0, 1'b0);
        expect_v(K_RD, A_S0, 32'h1, "R10 edge holds");
        expect_v(K_RD, A_FALL, 32'h0, "R1 rise-only no fall");
        wr(A_RISE, 32'h1);
        expect_v(K_RD, A_RISE, 32'h0, "R4 rise ack");
        expect_v(K_RD, EN_RD, 32'h0, "R5 ack clears enable");
        expect_v(K_REQ0, '0, 32'h0, "R5 req0 after ack");
        pin(0, 1'b1);
        expect_v(K_RD, A_RISE, 32'h1, "R5 latch while disabled");
        expect_v(K_RD, A_S0, 32'h0, "R5 enable blocks status");
        expect_v(K_REQ0, '0, 32'h0, "R5 enable blocks req0");
        pin(0, 1'b0);
        wr(A_RISE, 32'h1);
        wr(P0_CLR, 32'h1);

        // source 1 falling, steered to req1
        wr(P1_SET, 32'h2);
        wr(ST_CLR, 32'h2);
        wr(EN_SET, 32'h2);
        expect_v(K_RD, ST_RD, 32'hFFFF_FFFD, "R9 steer readback");
        pin(1, 1'b1);
        expect_v(K_RD, A_S1, 32'h0, "R1 fall-only ignores rise");
        expect_v(K_RD, A_RISE, 32'h0, "R1 no rise latch");
        pin(1, 1'b0);
        expect_v(K_RD, A_FALL, 32'h2, "R4 fall latch");
        expect_v(K_RD, A_S1, 32'h2, "R7 status1");
        expect_v(K_REQ1, '0, 32'h1, "R3 req1 high");
        expect_v(K_REQ0, '0, 32'h0, "R3 req0 stays low");
        wr(A_FALL, 32'h2);
        expect_v(K_RD, A_FALL, 32'h0, "R4 fall ack");
        expect_v(K_REQ1, '0, 32'h0, "R5 req1 after ack");
        wr(P1_CLR, 32'h2);

        // source 2 both edges
        wr(P0_SET, 32'h4);
        wr(P1_SET, 32'h4);
        wr(EN_SET, 32'h4);
        pin(2, 1'b1);
        expect_v(K_RD, A_RISE, 32'h4, "R1 both: rise");
        expect_v(K_RD, A_FALL, 32'h0, "R4 both: fall clear");
        wr(A_RISE, 32'h4);
        wr(EN_SET, 32'h4);
        pin(2, 1'b0);
        expect_v(K_RD, A_FALL, 32'h4, "R1 both: fall");
        expect_v(K_RD, A_S0, 32'h4, "R7 both: status0");
        wr(A_FALL, 32'h4);
        wr(P0_CLR, 32'h4);
        wr(P1_CLR, 32'h4);

        // source 3 high level
        wr(P2_SET, 32'h8);
        wr(P0_SET, 32'h8);
        wr(EN_SET, 32'h8);
        pin(3, 1'b1);
        expect_v(K_RD, A_S0, 32'h8, "R1 high level pending");
        expect_v(K_RD, A_RISE, 32'h0, "R10 level not latched");
        pin(3, 1'b0);
        expect_v(K_RD, A_S0, 32'h0, "R10 level follows pin");
        expect_v(K_REQ0, '0, 32'h0, "R10 req0 drops");
        wr(P0_CLR, 32'h8);
        wr(P2_CLR, 32'h8);
        wr(EN_CLR, 32'h8);

        // source 4 low level with wake
        wr(P2_SET, 32'h10);
        wr(P1_SET, 32'h10);
        expect_v(K_RD, A_S0, 32'h0, "R5 low level masked");
        expect_v(K_WAKE, '0, 32'h0, "R6 no wake bit");
        wr(WK_SET, 32'h10);
        expect_v(K_WAKE, '0, 32'h1, "R6 wake ignores enable");
        expect_v(K_RD, WK_RD, 32'h10, "R9 wake readback");
        pin(4, 1'b1);
        expect_v(K_WAKE, '0, 32'h0, "R1 low level inactive");
        pin(4, 1'b0);
        wr(EN_SET, 32'h10);
        expect_v(K_REQ0, '0, 32'h1, "R1 low level req0");
        wr(WK_CLR, 32'h10);
        expect_v(K_WAKE, '0, 32'h0, "R6 wake cleared");
        expect_v(K_REQ0, '0, 32'h1, "R6 enable kept");
        wr(P2_CLR, 32'h10);
        wr(P1_CLR, 32'h10);
        wr(EN_CLR, 32'h10);

        // source 5 invalid codes 111 then 100
        wr(P0_SET, 32'h20);
        wr(P1_SET, 32'h20);
        wr(P2_SET, 32'h20);
        wr(EN_SET, 32'h20);
        pin(5, 1'b1);
        expect_v(K_RD, A_S0, 32'h0, "R11 code 111 rise");
        expect_v(K_RD, A_RISE, 32'h0, "R11 code 111 latch");
        pin(5, 1'b0);
        expect_v(K_RD, A_FALL, 32'h0, "R11 code 111 fall");
        expect_v(K_REQ0, '0, 32'h0, "R11 code 111 req0");
        wr(P0_CLR, 32'h20);
        wr(P1_CLR, 32'h20);
        pin(5, 1'b1);
        expect_v(K_RD, A_S0, 32'h0, "R11 code 100 high");
        pin(5, 1'b0);
        expect_v(K_RD, A_S0, 32'h0, "R11 code 100 low");
        wr(P2_CLR, 32'h20);
        wr(EN_CLR, 32'h20);

        // source 6 driven from the test word
        wr(P0_SET, 32'h40);
        wr(EN_SET, 32'h40);
        wr(IS_CLR, 32'h40);
        pin(6, 1'b1);
        expect_v(K_RD, A_RISE, 32'h0, "R12 pin ignored");
        pin(6, 1'b0);
        wr(A_TEST, 32'h40);
        repeat (2) @(posedge clk);
        expect_v(K_RD, A_TEST, 32'h40, "R12 test readback");
        expect_v(K_RD, A_RISE, 32'h40, "R12 test drives source");
        expect_v(K_RD, A_S0, 32'h40, "R12 status from test");

        repeat (2) @(posedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule